// File: doc/BRIEF.md
# Programmable Parallel I/O Controller

This block gives a host three 8-bit parallel ports, called A, B and C, plus one control register. All four are reached over a simple byte-wide bus. That bus has an active-low chip select, active-low read and write strobes and a 2-bit register address.

A byte written to the control register does one of two jobs. If its top bit is set, it reconfigures the whole controller: the operating mode of each port and the direction of each one. If its top bit is clear, it forces a single port C line high or low. Ports A and B can run as plain latched ports or in a strobed handshake mode. Port A can also run in a bidirectional mode. In the handshake modes some port C lines stop being data bits and carry the strobe, acknowledge, buffer-status and interrupt signals of ports A and B.

The design is fully synchronous. Every pin is sampled on the rising clock edge. A port that can drive reports a drive enable beside its output value, so that pad logic outside the block can build the tri-state buffers. A host access counts once, on the first clock edge at which its strobe is seen low together with chip select. Read data is captured at that edge and is held on the bus until the strobe is released.

Top module: `pio_ctrl`

## Requirements
- R1: The register address picks the register: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. Read data is zero whenever no read is in progress. A read of the control register returns the current configuration, with bit 7 set.
- R2: While `cs_n` is high, a write strobe changes nothing and a read strobe returns zero.
- R3: A control write with bit 7 set stores a configuration. Its fields are: bit 6 selects bidirectional port A; otherwise bit 5 selects strobed port A. Bit 4 makes port A an input. Bit 3 selects strobed port B and bit 2 makes port B an input. Bit 1 makes port C bits 7..4 inputs and bit 0 makes port C bits 3..0 inputs. After reset the stored configuration is 0x97.
- R4: Each configuration write clears the output latches of A, B and C. It also returns the handshake lines to idle: both buffer-full flags are 0, both output-buffer-full lines are 1, both interrupts are 0 and every interrupt enable is 0.
- R5: Each half of port C takes its direction from its own bit. An input bit reads back the pin value; an output bit drives and reads back its latch.
- R6: A control write with bit 7 clear writes the value in bit 3 to the port C bit whose index is in bits 2..0. No other port C bit changes.
- R7: In basic mode an output port drives its latch with the enable high. An input port holds its enable low, and a read returns the pin value sampled at the previous clock edge.
- R8: In strobed input mode a falling edge on the strobe latches the port pins and sets the input-buffer-full flag. The strobe is PC4 for port A and PC2 for port B; the flag appears on PC5 for A and PC1 for B. A host read of that port clears the flag.
- R9: The interrupt request of port A is on PC3 and that of port B is on PC0. It is set by a strobe or acknowledge event only while the matching enable is 1. The enables are written by a bit set/reset command aimed at PC4 (A input side), PC6 (A output side) or PC2 (port B). A host read or write of the port that clears the buffer flag also clears its interrupt request.
- R10: In strobed output mode, a host write to the port drives the output-buffer-full line low; that line is PC7 for A and PC1 for B. A falling edge on the acknowledge input sets it high again. The acknowledge input is PC6 for A and PC2 for B.
- R11: Ports A and B keep separate modes. For example, A can run strobed input while B runs strobed output.
- R12: In bidirectional mode port A drives only while PC6 is low. PC4 strobes data in, and both sets of port A handshake lines are active.
- R13: A port C line taken over by a handshake ignores port C data writes and bit set/reset commands. The only exception is the enable bits named in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, zero when not reading |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output value |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output value |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin values, including strobe and acknowledge inputs |
| pc_out | output | 8 | Port C output values, including handshake status lines |
| pc_oe | output | 8 | Port C drive enable, one per bit |

## Verification
A wrong stored configuration shows at once on the drive enables. On the next control-register read it shows as a bad value. A latch or a handshake flag that is stuck or cleared at the wrong time shows on the port C status lines in the cycle after the strobe, acknowledge or host access that should have moved it. Each handshake sequence is therefore followed by a status check before the next stimulus. A bit set/reset command that touches the wrong bit, or a handshake line that has not been protected, changes the value read back from port C on the next access.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        AM_BASIC  = 2'b00,
        AM_STROBE = 2'b01,
        AM_BIDIR  = 2'b10
    } a_mode_e;

    typedef struct packed {
        a_mode_e a_mode;
        logic    a_in;
        logic    b_strobe;
        logic    b_in;
        logic    ch_in;
        logic    cl_in;
    } pio_cfg_t;

    localparam pio_cfg_t CFG_RST = '{a_mode: AM_BASIC, a_in: 1'b1, b_strobe: 1'b0,
                                     b_in: 1'b1, ch_in: 1'b1, cl_in: 1'b1};

    // port C line roles when a handshake owns them
    localparam logic [2:0] PC_IRQ_B   = 3'd0;
    localparam logic [2:0] PC_FLAG_B  = 3'd1;
    localparam logic [2:0] PC_STRB_B  = 3'd2;
    localparam logic [2:0] PC_IRQ_A   = 3'd3;
    localparam logic [2:0] PC_STB_A   = 3'd4;
    localparam logic [2:0] PC_IBF_A   = 3'd5;
    localparam logic [2:0] PC_ACK_A   = 3'd6;
    localparam logic [2:0] PC_OBF_A   = 3'd7;

    function automatic pio_cfg_t decode_cfg(input logic [7:0] w);
        pio_cfg_t c;
        c.a_mode   = w[6] ? AM_BIDIR : (w[5] ? AM_STROBE : AM_BASIC);
        c.a_in     = w[4];
        c.b_strobe = w[3];
        c.b_in     = w[2];
        c.ch_in    = w[1];
        c.cl_in    = w[0];
        return c;
    endfunction

    function automatic logic [7:0] encode_cfg(input pio_cfg_t c);
        return {1'b1, c.a_mode, c.a_in, c.b_strobe, c.b_in, c.ch_in, c.cl_in};
    endfunction

endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if #(
    parameter int AW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [AW-1:0]        addr,
    output logic                 rd_act,
    output logic [(1<<AW)-1:0]   wr_hit,
    output logic [(1<<AW)-1:0]   rd_hit
);
    localparam int NREG = 1 << AW;

    typedef struct packed {
        logic rd_seen;
        logic wr_seen;
    } bus_st_t;

    bus_st_t bus_d, bus_q;
    logic    wr_act, rd_start, wr_start;

    always_comb begin
        rd_act   = !cs_n && !rd_n;
        wr_act   = !cs_n && !wr_n;
        rd_start = rd_act && !bus_q.rd_seen;
        wr_start = wr_act && !bus_q.wr_seen;
        bus_d.rd_seen = rd_act;
        bus_d.wr_seen = wr_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign wr_hit[g] = wr_start && (addr == AW'(g));
        assign rd_hit[g] = rd_start && (addr == AW'(g));
    end

    assert_single_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_hit, rd_hit}));

endmodule

// File: rtl/pio_hs_unit.sv
module pio_hs_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         in_en,
    input  logic         out_en,
    input  logic         basic_in,
    input  logic         stb_n,
    input  logic         ack_n,
    input  logic         host_rd,
    input  logic         host_wr,
    input  logic         inte_in,
    input  logic         inte_out,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] in_data,
    output logic [W-1:0] out_data,
    output logic         ibf,
    output logic         obf_n,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] in_latch;
        logic [W-1:0] out_latch;
        logic         ibf;
        logic         obf_n;
        logic         irq;
        logic         stb_q;
        logic         ack_q;
    } hs_st_t;

    hs_st_t hs_d, hs_q;
    logic   stb_fall, ack_fall;

    always_comb begin
        hs_d       = hs_q;
        hs_d.stb_q = stb_n;
        hs_d.ack_q = ack_n;
        stb_fall   = in_en  && hs_q.stb_q && !stb_n;
        ack_fall   = out_en && hs_q.ack_q && !ack_n;

        if (basic_in) hs_d.in_latch = pin;
        if (host_rd && in_en) begin
            hs_d.ibf = 1'b0;
            hs_d.irq = 1'b0;
        end
        if (host_wr) begin
            hs_d.out_latch = wdata;
            if (out_en) begin
                hs_d.obf_n = 1'b0;
                hs_d.irq   = 1'b0;
            end
        end
        if (stb_fall) begin
            hs_d.in_latch = pin;
            hs_d.ibf      = 1'b1;
            if (inte_in) hs_d.irq = 1'b1;
        end
        if (ack_fall) begin
            hs_d.obf_n = 1'b1;
            if (inte_out) hs_d.irq = 1'b1;
        end
        if (clr) begin
            hs_d.in_latch  = '0;
            hs_d.out_latch = '0;
            hs_d.ibf       = 1'b0;
            hs_d.obf_n     = 1'b1;
            hs_d.irq       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q       <= '0;
            hs_q.obf_n <= 1'b1;
            hs_q.stb_q <= 1'b1;
            hs_q.ack_q <= 1'b1;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign in_data  = hs_q.in_latch;
    assign out_data = hs_q.out_latch;
    assign ibf      = hs_q.ibf;
    assign obf_n    = hs_q.obf_n;
    assign irq      = hs_q.irq;

    assert_ibf_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(in_en));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(inte_in || inte_out));

    assert_obf_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && out_en && !clr && ack_n) |=> !obf_n);

endmodule

// File: rtl/pio_pc_map.sv
module pio_pc_map
    import pio_pkg::*;
(
    input  pio_cfg_t   cfg,
    input  logic [7:0] latch,
    input  logic       ibf_a,
    input  logic       obf_a_n,
    input  logic       irq_a,
    input  logic       ibf_b,
    input  logic       obf_b_n,
    input  logic       irq_b,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe,
    output logic [7:0] own
);
    logic a_in_side, a_out_side;

    always_comb begin
        a_in_side  = (cfg.a_mode == AM_BIDIR) || (cfg.a_mode == AM_STROBE && cfg.a_in);
        a_out_side = (cfg.a_mode == AM_BIDIR) || (cfg.a_mode == AM_STROBE && !cfg.a_in);

        for (int i = 0; i < 8; i++) begin
            pc_oe[i] = (i >= 4) ? !cfg.ch_in : !cfg.cl_in;
        end
        pc_out = latch;
        own    = '0;

        if (a_in_side || a_out_side) begin
            own[PC_IRQ_A] = 1'b1; pc_oe[PC_IRQ_A] = 1'b1; pc_out[PC_IRQ_A] = irq_a;
        end
        if (a_in_side) begin
            own[PC_STB_A] = 1'b1; pc_oe[PC_STB_A] = 1'b0;
            own[PC_IBF_A] = 1'b1; pc_oe[PC_IBF_A] = 1'b1; pc_out[PC_IBF_A] = ibf_a;
        end
        if (a_out_side) begin
            own[PC_ACK_A] = 1'b1; pc_oe[PC_ACK_A] = 1'b0;
            own[PC_OBF_A] = 1'b1; pc_oe[PC_OBF_A] = 1'b1; pc_out[PC_OBF_A] = obf_a_n;
        end
        if (cfg.b_strobe) begin
            own[PC_IRQ_B]  = 1'b1; pc_oe[PC_IRQ_B]  = 1'b1; pc_out[PC_IRQ_B] = irq_b;
            own[PC_FLAG_B] = 1'b1; pc_oe[PC_FLAG_B] = 1'b1;
            pc_out[PC_FLAG_B] = cfg.b_in ? ibf_b : obf_b_n;
            own[PC_STRB_B] = 1'b1; pc_oe[PC_STRB_B] = 1'b0;
        end
    end

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] pa_in,
    output logic [7:0] pa_out,
    output logic       pa_oe,
    input  logic [7:0] pb_in,
    output logic [7:0] pb_out,
    output logic       pb_oe,
    input  logic [7:0] pc_in,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe
);
    localparam int DW = 8;
    localparam int AW = 2;

    typedef struct packed {
        pio_cfg_t      cfg;
        logic [7:0]    pc_latch;
        logic          inte_a_in;
        logic          inte_a_out;
        logic          inte_b;
        logic [7:0]    pc_in_q;
        logic [DW-1:0] rd_hold;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic          rd_act;
    logic [3:0]    wr_hit, rd_hit;
    logic [7:0]    own;
    logic [DW-1:0] a_in_data, a_out_data, b_in_data, b_out_data;
    logic          a_ibf, a_obf_n, a_irq, b_ibf, b_obf_n, b_irq;
    logic          a_in_side, a_out_side, a_basic_in, b_basic_in, b_in_en, b_out_en;
    logic          mode_set;
    logic [2:0]    bsr_idx;
    logic [DW-1:0] a_rd, b_rd, c_rd, rd_val;

    pio_bus_if #(.AW(AW)) u_bus (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .rd_act(rd_act), .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    always_comb begin
        a_in_side  = (ctl_q.cfg.a_mode == AM_BIDIR) ||
                     (ctl_q.cfg.a_mode == AM_STROBE && ctl_q.cfg.a_in);
        a_out_side = (ctl_q.cfg.a_mode == AM_BIDIR) ||
                     (ctl_q.cfg.a_mode == AM_STROBE && !ctl_q.cfg.a_in);
        a_basic_in = (ctl_q.cfg.a_mode == AM_BASIC) && ctl_q.cfg.a_in;
        b_basic_in = !ctl_q.cfg.b_strobe && ctl_q.cfg.b_in;
        b_in_en    = ctl_q.cfg.b_strobe && ctl_q.cfg.b_in;
        b_out_en   = ctl_q.cfg.b_strobe && !ctl_q.cfg.b_in;
        mode_set   = wr_hit[3] && wdata[7];
    end

    pio_hs_unit #(.W(DW)) u_port_a (
        .clk(clk), .rst_n(rst_n), .clr(mode_set),
        .in_en(a_in_side), .out_en(a_out_side), .basic_in(a_basic_in),
        .stb_n(pc_in[PC_STB_A]), .ack_n(pc_in[PC_ACK_A]),
        .host_rd(rd_hit[0]), .host_wr(wr_hit[0]),
        .inte_in(ctl_q.inte_a_in), .inte_out(ctl_q.inte_a_out),
        .pin(pa_in), .wdata(wdata),
        .in_data(a_in_data), .out_data(a_out_data),
        .ibf(a_ibf), .obf_n(a_obf_n), .irq(a_irq)
    );

    pio_hs_unit #(.W(DW)) u_port_b (
        .clk(clk), .rst_n(rst_n), .clr(mode_set),
        .in_en(b_in_en), .out_en(b_out_en), .basic_in(b_basic_in),
        .stb_n(pc_in[PC_STRB_B]), .ack_n(pc_in[PC_STRB_B]),
        .host_rd(rd_hit[1]), .host_wr(wr_hit[1]),
        .inte_in(ctl_q.inte_b), .inte_out(ctl_q.inte_b),
        .pin(pb_in), .wdata(wdata),
        .in_data(b_in_data), .out_data(b_out_data),
        .ibf(b_ibf), .obf_n(b_obf_n), .irq(b_irq)
    );

    pio_pc_map u_pc_map (
        .cfg(ctl_q.cfg), .latch(ctl_q.pc_latch),
        .ibf_a(a_ibf), .obf_a_n(a_obf_n), .irq_a(a_irq),
        .ibf_b(b_ibf), .obf_b_n(b_obf_n), .irq_b(b_irq),
        .pc_out(pc_out), .pc_oe(pc_oe), .own(own)
    );

    always_comb begin
        a_rd = (a_in_side || a_basic_in) ? a_in_data : a_out_data;
        b_rd = (b_in_en || b_basic_in) ? b_in_data : b_out_data;
        c_rd = (pc_oe & pc_out) | (~pc_oe & ctl_q.pc_in_q);
        case (addr)
            2'd0:    rd_val = a_rd;
            2'd1:    rd_val = b_rd;
            2'd2:    rd_val = c_rd;
            default: rd_val = encode_cfg(ctl_q.cfg);
        endcase
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.pc_in_q = pc_in;
        bsr_idx       = wdata[2:0];
        if (wr_hit[3]) begin
            if (wdata[7]) begin
                ctl_d.cfg        = decode_cfg(wdata);
                ctl_d.pc_latch   = '0;
                ctl_d.inte_a_in  = 1'b0;
                ctl_d.inte_a_out = 1'b0;
                ctl_d.inte_b     = 1'b0;
            end else if (own[bsr_idx]) begin
                if (bsr_idx == PC_STB_A && a_in_side)          ctl_d.inte_a_in  = wdata[3];
                if (bsr_idx == PC_ACK_A && a_out_side)         ctl_d.inte_a_out = wdata[3];
                if (bsr_idx == PC_STRB_B && ctl_q.cfg.b_strobe) ctl_d.inte_b    = wdata[3];
            end else begin
                ctl_d.pc_latch[bsr_idx] = wdata[3];
            end
        end
        if (wr_hit[2]) ctl_d.pc_latch = (ctl_q.pc_latch & own) | (wdata & ~own);
        if (|rd_hit)   ctl_d.rd_hold  = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.cfg <= CFG_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdata  = rd_act ? ctl_q.rd_hold : '0;
    assign pa_out = a_out_data;
    assign pa_oe  = (ctl_q.cfg.a_mode == AM_BIDIR) ? !pc_in[PC_ACK_A] : !ctl_q.cfg.a_in;
    assign pb_out = b_out_data;
    assign pb_oe  = !ctl_q.cfg.b_in;

    assert_cs_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(ctl_q.cfg) && $stable(ctl_q.pc_latch)));

    assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[3] && wdata[7]) |=> (pa_out == '0 && pb_out == '0));

    assert_bidir_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.cfg.a_mode == AM_BIDIR && pa_oe) |-> !pc_in[PC_ACK_A]);

    assert_strobe_pin_input_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cfg.b_strobe |-> !pc_oe[PC_STRB_B]);

endmodule

// File: tb/pio_ctrl_test.sv
module pio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = 8'hFF;
    logic [7:0] pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] sb_exp[$];
    string      sb_tag[$];
    logic       rd_first = 1'b0, rd_was = 1'b0;

    always #10 clk = ~clk;

    pio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares the first sampled cycle of each read
    always @(posedge clk) begin
        rd_first <= !cs_n && !rd_n && !rd_was;
        rd_was   <= !cs_n && !rd_n;
    end

    always @(negedge clk) begin
        if (rd_first) begin
            if (sb_exp.size() == 0) chk(rdata, 8'hxx, "scoreboard underrun");
            else chk(rdata, sb_exp.pop_front(), sb_tag.pop_front());
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sb_exp.push_back(exp);
        sb_tag.push_back(tag);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_c(input int b);
        @(negedge clk);
        pc_in[b] = 1'b0;
        @(negedge clk);
        pc_in[b] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk({7'b0, pa_oe}, 8'h00, "R3 reset pa_oe");
        chk({7'b0, pb_oe}, 8'h00, "R3 reset pb_oe");
        chk(pc_oe, 8'h00, "R3 reset pc_oe");
        bus_rd(2'd3, 8'h97, "R3 reset config");

        // basic outputs, address decode
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h5A);
        bus_wr(2'd1, 8'hC3);
        bus_wr(2'd2, 8'h81);
        chk(pa_out, 8'h5A, "R7 pa_out");
        chk({7'b0, pa_oe}, 8'h01, "R7 pa_oe");
        chk(pb_out, 8'hC3, "R1 pb_out");
        chk(pc_out, 8'h81, "R1 pc_out");
        chk(pc_oe, 8'hFF, "R5 all C out");
        bus_rd(2'd0, 8'h5A, "R1 read A");
        bus_rd(2'd1, 8'hC3, "R1 read B");
        bus_rd(2'd2, 8'h81, "R1 read C");
        bus_rd(2'd3, 8'h80, "R3 read config");

        // chip select high blocks access
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'hFF;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        chk(pa_out, 8'h5A, "R2 write ignored");
        rd_n = 1'b0;
        @(negedge clk);
        chk(rdata, 8'h00, "R2 read blocked");
        rd_n = 1'b1;
        @(negedge clk);

        // bit set/reset
        bus_wr(2'd3, 8'h0D);
        chk(pc_out, 8'hA1, "R6 set bit5");
        bus_wr(2'd3, 8'h00);
        chk(pc_out, 8'hA0, "R6 clear bit0");

        // mode set clears latches
        bus_wr(2'd3, 8'h80);
        chk(pa_out, 8'h00, "R4 A cleared");
        chk(pb_out, 8'h00, "R4 B cleared");
        chk(pc_out, 8'h00, "R4 C cleared");

        // split port C
        bus_wr(2'd3, 8'h82);
        bus_wr(2'd2, 8'hFF);
        pc_in = 8'hA5;
        chk(pc_oe, 8'h0F, "R5 halves oe");
        bus_rd(2'd2, 8'hAF, "R5 mixed read");
        pc_in = 8'hFF;

        // basic inputs
        bus_wr(2'd3, 8'h97);
        pa_in = 8'h3C; pb_in = 8'h66;
        bus_rd(2'd0, 8'h3C, "R7 read A in");
        bus_rd(2'd1, 8'h66, "R7 read B in");

        // A strobed input, B strobed output
        bus_wr(2'd3, 8'hB8);
        chk(pc_oe, 8'hEB, "R11 handshake oe");
        chk(pc_out, 8'h02, "R11 idle lines");
        bus_rd(2'd3, 8'hB8, "R11 config");
        bus_wr(2'd3, 8'h0C);
        pa_in = 8'h77;
        pulse_c(4);
        chk({7'b0, pc_out[5]}, 8'h01, "R8 ibf set");
        chk({7'b0, pc_out[3]}, 8'h01, "R9 irq A set");
        pa_in = 8'h00;
        bus_rd(2'd0, 8'h77, "R8 latched data");
        chk({7'b0, pc_out[5]}, 8'h00, "R8 ibf cleared");
        chk({7'b0, pc_out[3]}, 8'h00, "R9 irq A cleared");
        bus_wr(2'd3, 8'h04);
        pa_in = 8'h11;
        pulse_c(4);
        chk({7'b0, pc_out[5]}, 8'h01, "R8 ibf set again");
        chk({7'b0, pc_out[3]}, 8'h00, "R9 irq A masked");
        bus_rd(2'd0, 8'h11, "R8 second data");

        bus_wr(2'd1, 8'h99);
        chk(pb_out, 8'h99, "R10 pb_out");
        chk({7'b0, pb_oe}, 8'h01, "R10 pb_oe");
        chk({7'b0, pc_out[1]}, 8'h00, "R10 obf low");
        pulse_c(2);
        chk({7'b0, pc_out[1]}, 8'h01, "R10 obf released");
        chk({7'b0, pc_out[0]}, 8'h00, "R9 irq B masked");
        bus_wr(2'd3, 8'h0A);
        bus_wr(2'd1, 8'h5B);
        chk({7'b0, pc_out[1]}, 8'h00, "R10 obf low again");
        pulse_c(2);
        chk({7'b0, pc_out[0]}, 8'h01, "R9 irq B set");
        bus_wr(2'd1, 8'h00);
        chk({7'b0, pc_out[0]}, 8'h00, "R9 irq B cleared by write");

        // protected handshake lines
        bus_wr(2'd2, 8'hFF);
        chk(pc_out, 8'hC0, "R13 data write masked");
        bus_wr(2'd3, 8'h0D);
        chk(pc_out, 8'hC0, "R13 bsr masked");
        bus_rd(2'd2, 8'hD4, "R13 read C");

        // bidirectional port A
        bus_wr(2'd3, 8'hC0);
        chk({7'b0, pa_oe}, 8'h00, "R12 idle no drive");
        chk({7'b0, pc_out[7]}, 8'h01, "R12 obf idle");
        bus_wr(2'd0, 8'h42);
        chk({7'b0, pc_out[7]}, 8'h00, "R10 A obf low");
        bus_wr(2'd3, 8'hC0);
        chk({7'b0, pc_out[7]}, 8'h01, "R4 obf back to idle");
        chk(pa_out, 8'h00, "R4 A latch cleared");
        bus_wr(2'd0, 8'h42);
        @(negedge clk);
        pc_in[6] = 1'b0;
        @(negedge clk);
        chk({7'b0, pa_oe}, 8'h01, "R12 drive on ack");
        chk(pa_out, 8'h42, "R12 out data");
        chk({7'b0, pc_out[7]}, 8'h01, "R12 obf released");
        pc_in[6] = 1'b1;
        @(negedge clk);
        chk({7'b0, pa_oe}, 8'h00, "R12 drive off");
        pa_in = 8'h1E;
        pulse_c(4);
        bus_rd(2'd0, 8'h1E, "R12 strobed in");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule